// File: doc/BRIEF.md
# Complementary-Output PWM Timer

This block is an 8-bit up-counter that drives two compare channels. Each channel has its own compare register. A shared period register sets the count at which the counter returns to zero. The counter advances only on cycles where an external clock-enable strobe is high. That strobe normally comes from a prescaler outside the block, and all compare and flag activity follows the same strobe.

Each channel drives a true pin and an inverted pin. In PWM operation the true pin falls when the counter steps onto the channel's compare value and rises when the counter steps onto 1. The inverted pin is its complement, so the two pins are never high together. Without PWM, a channel acts as a plain compare output that toggles, clears or sets on a match. A force strobe can apply that same action on demand.

Software reaches the block through a single write port. Compare flags and the overflow flag are sticky, and software clears them by writing ones.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset the count is 0, the period register is 255, every compare register is 0, all pins are low and all flags are clear. The count rises by one on each cycle with `tick_i` high and holds on every other cycle.
- R2: On a tick where the count is greater than or equal to the period register (address 3), the count becomes 0 and the overflow flag sets.
- R3: A write to address 0 loads the count. This load takes priority over a tick in the same cycle and never causes a compare match, even when the loaded value equals a compare register.
- R4: A channel's compare flag sets when a tick moves the count onto that channel's compare value (address 1 for channel A, address 2 for channel B). Writing address 6 clears flags wherever the data bit is one: bit 0 for channel A, bit 1 for channel B, bit 2 for overflow. A flag that sets in the same cycle as a clear stays set.
- R5: With the channel's PWM bit set and its mode at 01, the true pin goes low on the tick that moves the count onto the compare value. It goes high on the tick that moves the count onto 1. The inverted pin is the complement of the true pin.
- R6: In PWM operation, a compare value of 0 holds the true pin low on every tick. A nonzero compare value greater than or equal to the period holds the true pin high on every tick.
- R7: With the PWM bit clear, a compare match changes the output state according to the mode: 01 toggles it, 10 clears it and 11 sets it. Mode 00 drives both pins low.
- R8: Writing address 5 with data bit 0 (channel A) or bit 1 (channel B) applies the channel's non-PWM match action at once and leaves its flag untouched. The force write is ignored while the channel's PWM bit is set.
- R9: The mode register is at address 4. Channel A's mode sits in bits 1:0 and channel B's in bits 3:2. The PWM bit is bit 4 for channel A and bit 5 for channel B. In PWM operation, mode 10 drives only the true pin (the inverted pin stays low) and mode 11 drives only the inverted pin. The true and inverted pins of a channel are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| count_o | output | 8 | Current count |
| oc_o | output | 2 | True output pin per channel (bit 0 = A) |
| ocn_o | output | 2 | Inverted output pin per channel |
| cmp_flag_o | output | 2 | Sticky compare flag per channel |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
A counter that goes wrong shows up on `count_o` on the very next tick. It also shifts every later pin edge and flag, so one extra or missing step disturbs the whole following period. A wrong per-channel output state shows as a pin level that disagrees with the expected waveform within one tick of the match or wrap that should have set it. A corrupted compare or period register shows as a pin edge or flag landing on the wrong count, within at most one full period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    OM_OFF = 2'b00,
    OM_TGL = 2'b01,  // PWM: complementary pair
    OM_CLR = 2'b10,  // PWM: true pin only
    OM_SET = 2'b11   // PWM: inverted pin only
  } out_mode_e;

  function automatic logic match_action(out_mode_e m, logic s);
    unique case (m)
      OM_TGL:  return !s;
      OM_CLR:  return 1'b0;
      OM_SET:  return 1'b1;
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int CNT_W = 8,
  parameter int N_CH  = 2,
  parameter int AW    = 3,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  output logic [N_CH-1:0][CNT_W-1:0] cmp_q_o,
  output logic [CNT_W-1:0]           period_q_o,
  output logic [N_CH-1:0][1:0]       mode_q_o,
  output logic [N_CH-1:0]            pwm_en_q_o,
  output logic                       cnt_wr_o,
  output logic [N_CH-1:0]            force_o,
  output logic [N_CH-1:0]            clr_cmp_o,
  output logic                       clr_ovf_o
);
  localparam logic [AW-1:0] A_CNT  = '0;
  localparam logic [AW-1:0] A_PER  = AW'(N_CH + 1);
  localparam logic [AW-1:0] A_MODE = AW'(N_CH + 2);
  localparam logic [AW-1:0] A_FRC  = AW'(N_CH + 3);
  localparam logic [AW-1:0] A_CLR  = AW'(N_CH + 4);

  logic wr_frc, wr_clr;

  always_comb begin
    cnt_wr_o  = wr_en_i && (wr_addr_i == A_CNT);
    wr_frc    = wr_en_i && (wr_addr_i == A_FRC);
    wr_clr    = wr_en_i && (wr_addr_i == A_CLR);
    force_o   = wr_frc ? wr_data_i[N_CH-1:0] : '0;
    clr_cmp_o = wr_clr ? wr_data_i[N_CH-1:0] : '0;
    clr_ovf_o = wr_clr && wr_data_i[N_CH];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q_o    <= '0;
      period_q_o <= PERIOD_RST;
      mode_q_o   <= '0;
      pwm_en_q_o <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < N_CH; i++) begin
        if (wr_addr_i == AW'(i + 1)) cmp_q_o[i] <= wr_data_i;
      end
      if (wr_addr_i == A_PER) period_q_o <= wr_data_i;
      if (wr_addr_i == A_MODE) begin
        for (int i = 0; i < N_CH; i++) begin
          mode_q_o[i]   <= wr_data_i[2*i +: 2];
          pwm_en_q_o[i] <= wr_data_i[2*N_CH + i];
        end
      end
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             clr_ovf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             adv_o,
  output logic             ovf_flag_o
);
  logic wrap;

  always_comb begin
    adv_o     = tick_i && !cnt_wr_i;  // a software load suppresses the step
    wrap      = adv_o && (cnt_o >= period_i);
    cnt_nxt_o = wrap ? '0 : cnt_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '0;
      ovf_flag_o <= 1'b0;
    end else begin
      if (cnt_wr_i)   cnt_o <= wr_data_i;
      else if (adv_o) cnt_o <= cnt_nxt_o;
      if (wrap)           ovf_flag_o <= 1'b1;
      else if (clr_ovf_i) ovf_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel import pwm_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  out_mode_e        mode_i,
  input  logic             pwm_en_i,
  input  logic             force_i,
  input  logic             clr_flag_i,
  output logic             oc_o,
  output logic             ocn_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic match, s_q, s_d;

  always_comb begin
    match = adv_i && (cnt_nxt_i == cmp_i);
    s_d   = s_q;
    if (pwm_en_i) begin
      if (adv_i) begin
        // degenerate duty values pin the level so no one-count pulse escapes
        if (cmp_i == '0)              s_d = 1'b0;
        else if (cmp_i >= period_i)   s_d = 1'b1;
        else if (cnt_nxt_i == cmp_i)  s_d = 1'b0;
        else if (cnt_nxt_i == ONE)    s_d = 1'b1;
      end
    end else if (match || force_i) begin
      s_d = match_action(mode_i, s_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q    <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      s_q <= s_d;
      if (match)           flag_o <= 1'b1;
      else if (clr_flag_i) flag_o <= 1'b0;
    end
  end

  always_comb begin
    oc_o  = 1'b0;
    ocn_o = 1'b0;
    if (mode_i != OM_OFF) begin
      if (!pwm_en_i || mode_i == OM_TGL) begin
        oc_o  = s_q;
        ocn_o = !s_q;
      end else if (mode_i == OM_CLR) begin
        oc_o  = s_q;
      end else begin
        ocn_o = !s_q;
      end
    end
  end
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top import pwm_pkg::*; #(
  parameter int CNT_W = 8,
  parameter int N_CH  = 2,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1,
  localparam int AW = $clog2(N_CH + 5)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [N_CH-1:0]  oc_o,
  output logic [N_CH-1:0]  ocn_o,
  output logic [N_CH-1:0]  cmp_flag_o,
  output logic             ovf_flag_o
);
  logic [N_CH-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]           period_q;
  logic [N_CH-1:0][1:0]       mode_q;
  logic [N_CH-1:0]            pwm_en_q;
  logic                       cnt_wr;
  logic [N_CH-1:0]            force_p;
  logic [N_CH-1:0]            clr_cmp;
  logic                       clr_ovf;
  logic [CNT_W-1:0]           cnt_nxt;
  logic                       adv;

  pwm_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .AW(AW), .PERIOD_RST(PERIOD_RST)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .cmp_q_o    (cmp_q),
    .period_q_o (period_q),
    .mode_q_o   (mode_q),
    .pwm_en_q_o (pwm_en_q),
    .cnt_wr_o   (cnt_wr),
    .force_o    (force_p),
    .clr_cmp_o  (clr_cmp),
    .clr_ovf_o  (clr_ovf)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .cnt_wr_i   (cnt_wr),
    .wr_data_i  (wr_data_i),
    .period_i   (period_q),
    .clr_ovf_i  (clr_ovf),
    .cnt_o      (count_o),
    .cnt_nxt_o  (cnt_nxt),
    .adv_o      (adv),
    .ovf_flag_o (ovf_flag_o)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .adv_i      (adv),
      .cnt_nxt_i  (cnt_nxt),
      .period_i   (period_q),
      .cmp_i      (cmp_q[i]),
      .mode_i     (out_mode_e'(mode_q[i])),
      .pwm_en_i   (pwm_en_q[i]),
      .force_i    (force_p[i]),
      .clr_flag_i (clr_cmp[i]),
      .oc_o       (oc_o[i]),
      .ocn_o      (ocn_o[i]),
      .flag_o     (cmp_flag_o[i])
    );
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int CNT_W = 8,
  parameter int N_CH  = 2,
  parameter int AW    = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick_i,
  input logic                       wr_en_i,
  input logic [AW-1:0]              wr_addr_i,
  input logic [CNT_W-1:0]           wr_data_i,
  input logic [CNT_W-1:0]           count_o,
  input logic [N_CH-1:0]            oc_o,
  input logic [N_CH-1:0]            ocn_o,
  input logic [N_CH-1:0]            cmp_flag_o,
  input logic                       ovf_flag_o,
  input logic [CNT_W-1:0]           period_q,
  input logic [N_CH-1:0][CNT_W-1:0] cmp_q,
  input logic [N_CH-1:0][1:0]       mode_q,
  input logic [N_CH-1:0]            pwm_en_q
);
  logic ld, step;
  assign ld   = wr_en_i && (wr_addr_i == '0);
  assign step = tick_i && !ld;

  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !ld |=> $stable(count_o));
  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && (count_o < period_q) |=> count_o == $past(count_o) + 1'b1);
  // R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && (count_o >= period_q) |=> (count_o == '0) && ovf_flag_o);
  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> count_o == $past(wr_data_i));
  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_o & ocn_o) == '0);

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R3 R4
    flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cmp_flag_o[i]) |-> $past(step));
    // R7
    off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_q[i] == 2'b00 |-> !oc_o[i] && !ocn_o[i]);
    // R6
    zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(step && pwm_en_q[i] && cmp_q[i] == '0) && pwm_en_q[i] && mode_q[i] == 2'b01
      |-> !oc_o[i]);
    // R6
    full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(step && pwm_en_q[i] && cmp_q[i] != '0 && cmp_q[i] >= period_q)
      && pwm_en_q[i] && mode_q[i] == 2'b01 |-> oc_o[i]);
  end
endmodule

bind pwm_timer_top pwm_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .count_o    (count_o),
  .oc_o       (oc_o),
  .ocn_o      (ocn_o),
  .cmp_flag_o (cmp_flag_o),
  .ovf_flag_o (ovf_flag_o),
  .period_q   (period_q),
  .cmp_q      (cmp_q),
  .mode_q     (mode_q),
  .pwm_en_q   (pwm_en_q)
);

// File: tb/tb_pwm_timer_top.sv
module tb_pwm_timer_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] count_o;
  logic [1:0] oc_o, ocn_o, cmp_flag_o;
  logic       ovf_flag_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_cnt, m_per;
  logic [7:0] m_cmp [2];
  logic [1:0] m_mode [2];
  logic       m_pwm [2];
  logic       m_s [2];
  logic       m_cf [2];
  logic       m_ovf;

  pwm_timer_top dut (.*);

  always #(CLK_PERIOD/2) clk_i = !clk_i;

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_pins(int c);
    if (m_mode[c] == 2'b00) return 2'b00;
    if (!m_pwm[c] || m_mode[c] == 2'b01) return {m_s[c], !m_s[c]};
    if (m_mode[c] == 2'b10) return {m_s[c], 1'b0};
    return {1'b0, !m_s[c]};
  endfunction

  task automatic model(logic t, logic we, logic [2:0] a, logic [7:0] d);
    logic adv = t && !(we && a == 3'd0);
    logic wrap = adv && (m_cnt >= m_per);
    logic [7:0] nxt = wrap ? 8'd0 : m_cnt + 8'd1;
    for (int c = 0; c < 2; c++) begin
      logic match = adv && (nxt == m_cmp[c]);
      logic frc = we && a == 3'd5 && d[c];
      logic clr = we && a == 3'd6 && d[c];
      if (m_pwm[c]) begin
        if (adv) begin
          if (m_cmp[c] == 0) m_s[c] = 1'b0;
          else if (m_cmp[c] >= m_per) m_s[c] = 1'b1;
          else if (nxt == m_cmp[c]) m_s[c] = 1'b0;
          else if (nxt == 8'd1) m_s[c] = 1'b1;
        end
      end else if (match || frc) begin
        case (m_mode[c])
          2'b01: m_s[c] = !m_s[c];
          2'b10: m_s[c] = 1'b0;
          2'b11: m_s[c] = 1'b1;
          default: ;
        endcase
      end
      if (match) m_cf[c] = 1'b1;
      else if (clr) m_cf[c] = 1'b0;
    end
    if (wrap) m_ovf = 1'b1;
    else if (we && a == 3'd6 && d[2]) m_ovf = 1'b0;
    if (we && a == 3'd0) m_cnt = d;
    else if (adv) m_cnt = nxt;
    if (we && a == 3'd1) m_cmp[0] = d;
    if (we && a == 3'd2) m_cmp[1] = d;
    if (we && a == 3'd3) m_per = d;
    if (we && a == 3'd4) begin
      m_mode[0] = d[1:0]; m_mode[1] = d[3:2];
      m_pwm[0] = d[4];    m_pwm[1] = d[5];
    end
  endtask

  task automatic check_model();
    chk("R1 count", count_o, m_cnt);
    chk("R2 overflow flag", {7'd0, ovf_flag_o}, {7'd0, m_ovf});
    chk("R4 compare flags", {6'd0, cmp_flag_o}, {6'd0, m_cf[1], m_cf[0]});
    for (int c = 0; c < 2; c++)
      chk("R9 pins", {6'd0, oc_o[c], ocn_o[c]}, {6'd0, exp_pins(c)});
  endtask

  task automatic cyc(logic t, logic we, logic [2:0] a, logic [7:0] d);
    tick_i = t; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    model(t, we, a, d);
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check_model();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'h5eed_1234));
    m_cnt = 0; m_per = 8'hFF; m_cmp[0] = 0; m_cmp[1] = 0;
    m_mode[0] = 0; m_mode[1] = 0; m_pwm[0] = 0; m_pwm[1] = 0;
    m_s[0] = 0; m_s[1] = 0; m_cf[0] = 0; m_cf[1] = 0; m_ovf = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 reset count", count_o, 8'd0);
    chk("R1 reset pins", {4'd0, oc_o, ocn_o}, 8'd0);
    chk("R1 reset flags", {5'd0, ovf_flag_o, cmp_flag_o}, 8'd0);
    tk(3);
    chk("R1 three ticks", count_o, 8'd3);
    cyc(1'b0, 1'b0, 3'd0, 8'd0);
    chk("R1 hold without tick", count_o, 8'd3);

    // R5 PWM pair on channel A, period 9, compare 4
    wr(3'd3, 8'd9); wr(3'd1, 8'd4); wr(3'd4, 8'h11); wr(3'd0, 8'd0); wr(3'd6, 8'h07);
    tk(1);
    chk("R5 set at one", {6'd0, oc_o[0], ocn_o[0]}, 8'b10);
    tk(3);
    chk("R5 clear at compare", {6'd0, oc_o[0], ocn_o[0]}, 8'b01);
    chk("R4 flag on match", {7'd0, cmp_flag_o[0]}, 8'd1);
    tk(5);
    chk("R2 no wrap below period", {7'd0, ovf_flag_o}, 8'd0);
    tk(1);
    chk("R2 wrap count", count_o, 8'd0);
    chk("R2 wrap flag", {7'd0, ovf_flag_o}, 8'd1);

    // R4 write-one-to-clear and set-over-clear
    wr(3'd6, 8'h01);
    chk("R4 W1C flag A", {7'd0, cmp_flag_o[0]}, 8'd0);
    chk("R4 ovf untouched", {7'd0, ovf_flag_o}, 8'd1);
    tk(3);
    cyc(1'b1, 1'b1, 3'd6, 8'h01);
    chk("R4 set wins over clear", {7'd0, cmp_flag_o[0]}, 8'd1);

    // R3 load equal to compare, with a tick in the same cycle
    wr(3'd6, 8'h07);
    cyc(1'b1, 1'b1, 3'd0, 8'd4);
    chk("R3 load wins", count_o, 8'd4);
    chk("R3 no match on load", {7'd0, cmp_flag_o[0]}, 8'd0);
    tk(1);
    chk("R3 no late match", {7'd0, cmp_flag_o[0]}, 8'd0);

    // R6 constant levels
    wr(3'd1, 8'd0); wr(3'd0, 8'd0);
    for (int i = 0; i < 12; i++) begin
      tk(1);
      chk("R6 zero duty low", {7'd0, oc_o[0]}, 8'd0);
    end
    wr(3'd1, 8'd9);
    for (int i = 0; i < 12; i++) begin
      tk(1);
      chk("R6 full duty high", {7'd0, oc_o[0]}, 8'd1);
    end

    // R7 non-PWM compare modes
    wr(3'd4, 8'h01); wr(3'd1, 8'd3); wr(3'd0, 8'd0);
    tk(3);
    chk("R7 toggle low", {6'd0, oc_o[0], ocn_o[0]}, 8'b01);
    tk(10);
    chk("R7 toggle high", {6'd0, oc_o[0], ocn_o[0]}, 8'b10);
    wr(3'd4, 8'h02); tk(10);
    chk("R7 clear mode", {7'd0, oc_o[0]}, 8'd0);
    wr(3'd4, 8'h03); tk(10);
    chk("R7 set mode", {7'd0, oc_o[0]}, 8'd1);

    // R8 force strobe
    wr(3'd4, 8'h01); wr(3'd6, 8'h07); wr(3'd5, 8'h01);
    chk("R8 force toggles", {7'd0, oc_o[0]}, 8'd0);
    chk("R8 force no flag", {7'd0, cmp_flag_o[0]}, 8'd0);
    wr(3'd4, 8'h11);
    keep = {7'd0, oc_o[0]};
    wr(3'd5, 8'h01);
    chk("R8 force ignored in PWM", {7'd0, oc_o[0]}, keep);

    // R9 single-pin PWM variants on channel B
    wr(3'd2, 8'd5); wr(3'd4, 8'h28);
    for (int i = 0; i < 12; i++) begin
      tk(1);
      chk("R9 true-only keeps inverted low", {7'd0, ocn_o[1]}, 8'd0);
    end
    wr(3'd4, 8'h2C);
    for (int i = 0; i < 12; i++) begin
      tk(1);
      chk("R9 inverted-only keeps true low", {7'd0, oc_o[1]}, 8'd0);
    end
    wr(3'd4, 8'h00);
    chk("R7 mode off pins low", {4'd0, oc_o, ocn_o}, 8'd0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic t = ($urandom % 4) != 0;
      logic we = ($urandom % 6) == 0;
      logic [2:0] a = 3'($urandom % 7);
      logic [7:0] d = 8'($urandom);
      if (a == 3'd3 && d < 8'd4) d = 8'd4 + d;
      cyc(t, we, a, d);
      chk("R9 never both high", {6'd0, oc_o & ocn_o}, 8'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule